// File: doc/BRIEF.md
# MDIO Indirect PHY Register Access Engine

This block lets a host reach the registers of external PHYs over a two-wire management bus. The bus has a clock line (MDC) and a bidirectional data line (MDIO). The host sees two 16-bit registers: a command register and a data register. To write a PHY register, the host loads the value into the data register. It then writes a command word with the busy bit set. To read a PHY register, the host writes the command word, polls until busy clears, and then takes the result from the data register.

Once a command is accepted, the engine builds the whole management frame and shifts it out on its own. The frame can use the older clause 22 format or the extended clause 45 format. MDC is produced by dividing the system clock. For reads, the engine releases MDIO during the turnaround and data bits, samples the PHY's answer, and stores it in the data register.

Top module: `mdio_indirect_engine`

## Requirements
- R1: After reset, the command register reads 0, the data register reads 0, MDC is low and MDIO is not driven.
- R2: The command register sits at host address 0x18 and the data register at 0x19. Command bit 15 is busy, bit 12 selects clause 22 when set and clause 45 when clear, bits 11:10 are the opcode, bits 9:5 are the PHY address and bits 4:0 are the register or device number. Any other address reads 0.
- R3: A clause 22 frame is sent MSB first as:
  - 32 ones;
  - start bits 01;
  - on-wire opcode 01 for a write (opcode 1) or 10 for a read (opcode 2);
  - the 5-bit PHY address, then the 5-bit register number;
  - turnaround bits 10;
  - for a write, the 16-bit data register value.
- R4: A clause 45 frame uses start bits 00. Opcode 0 (address) is sent as 00, opcode 1 (write) as 01 and opcode 2 (read) as 11. Address and write frames carry the data register value as their last 16 bits.
- R5: During a read, MDIO is released for the last 18 bit times of the frame. The 16 data bits are sampled on rising MDC edges, MSB first. They are written to the data register in the same cycle that busy clears.
- R6: MDC stays low while idle. Each MDC half-period lasts HALF_DIV system clocks.
- R7: Writing the command register with bit 15 set and a valid opcode sets busy. Busy stays set for exactly 64 MDC cycles (one full frame) and then clears.
- R8: A command write that arrives while busy is set is ignored: the command readback and the frame on the wire are unchanged.
- R9: A data register write during a transaction does not change the bits being shifted out. The data register still takes the new value.
- R10: A command written with bit 15 clear, or with an undefined opcode, does not start a frame. Undefined opcodes are 0 or 3 in clause 22 and 3 in clause 45. Its fields are stored, busy reads 0 and MDC does not toggle.
- R11: A write frame drives MDIO for all 64 bit times, and MDIO is not driven while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the addressed register |
| mdc | output | 1 | Management bus clock |
| mdio_out | output | 1 | Management data value driven by the engine |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data value seen on the wire |

## Verification
The assertions assume that the host writes at most one register per cycle. They also assume that the clock divider parameter is at least one. The bench follows the required protocol: it loads data before it issues a command, and polls busy before the next command. The only exceptions are the deliberate writes during a transaction that test R8 and R9. The PHY responder in the bench changes MDIO only between rising MDC edges, so every sampled bit is stable when the engine takes it.

// File: rtl/mdio_indirect_engine.sv
module mdio_indirect_engine #(
  parameter int         HALF_DIV  = 2,
  parameter int         PRE_LEN   = 32,
  parameter logic [4:0] CMD_ADDR  = 5'h18,
  parameter logic [4:0] DATA_ADDR = 5'h19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FLEN     = PRE_LEN + 32;
  localparam int BW       = $clog2(FLEN + 1);
  localparam int DVW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int RX_FIRST = FLEN - 16;
  localparam int OE_LAST  = FLEN - 18;

  logic            busy;
  logic            rd;
  logic [14:0]     cmd;
  logic [15:0]     data;
  logic [15:0]     rx;
  logic [FLEN-1:0] sh;
  logic [BW-1:0]   bitn;
  logic [DVW-1:0]  div;

  logic       cmd_wr, dat_wr, n_c22, n_rd, n_ok, go, tick, last;
  logic [1:0] n_op, st_f, op_f, ta_f;
  logic [FLEN-1:0] frame;

  assign cmd_wr = host_we && (host_addr == CMD_ADDR) && !busy;
  assign dat_wr = host_we && (host_addr == DATA_ADDR);
  assign n_c22  = host_wdata[12];
  assign n_op   = host_wdata[11:10];
  assign n_rd   = (n_op == 2'd2);
  assign n_ok   = n_c22 ? (n_op == 2'd1 || n_op == 2'd2) : (n_op != 2'd3);
  assign go     = cmd_wr && host_wdata[15] && n_ok;

  assign st_f  = n_c22 ? 2'b01 : 2'b00;
  assign op_f  = n_c22 ? (n_rd ? 2'b10 : 2'b01) : (n_rd ? 2'b11 : {1'b0, n_op[0]});
  assign ta_f  = n_rd ? 2'b11 : 2'b10;
  assign frame = {{PRE_LEN{1'b1}}, st_f, op_f, host_wdata[9:5], host_wdata[4:0],
                  ta_f, (n_rd ? 16'hFFFF : data)};

  assign tick = (div == DVW'(HALF_DIV - 1));
  assign last = (bitn == BW'(FLEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rd   <= 1'b0;
      cmd  <= '0;
      data <= '0;
      rx   <= '0;
      sh   <= '0;
      bitn <= '0;
      div  <= '0;
      mdc  <= 1'b0;
    end else begin
      if (dat_wr) data <= host_wdata;
      if (cmd_wr) begin
        cmd <= host_wdata[14:0];
        if (go) begin
          busy <= 1'b1;
          rd   <= n_rd;
          sh   <= frame;
          bitn <= '0;
          div  <= '0;
          mdc  <= 1'b0;
        end
      end else if (busy) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick && !mdc) begin
          mdc <= 1'b1;
          if (rd && bitn >= BW'(RX_FIRST)) rx <= {rx[14:0], mdio_in};
        end
        if (tick && mdc) begin
          mdc <= 1'b0;
          if (last) begin
            busy <= 1'b0;
            if (rd) data <= rx;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[FLEN-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdio_out = sh[FLEN-1];
  assign mdio_oe  = busy && (!rd || bitn < BW'(OE_LAST));

  always_comb begin
    if (host_addr == CMD_ADDR)       host_rdata = {busy, cmd};
    else if (host_addr == DATA_ADDR) host_rdata = data;
    else                             host_rdata = 16'h0000;
  end

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd)); // R8
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R6
  AST_MDIO_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R11
  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(busy)); // R10
  AST_WRITE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd && !dat_wr) |=> $stable(data)); // R9
  AST_OUT_ON_LOW_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy) && mdc) |-> $stable(mdio_out)); // R6
endmodule

// File: tb/mdio_indirect_engine_test.sv
module mdio_indirect_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = 5'h0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mdio_indirect_engine uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int          rise_cnt = 0;
  int          base = 0;
  logic [15:0] drv_val = 16'h0;
  logic [63:0] cap = '0;
  logic [63:0] cap_oe = '0;

  always @(posedge mdc) begin
    cap      <= {cap[62:0], mdio_out};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
  end

  int rel;
  assign rel = rise_cnt - base;
  assign mdio_in = (rel >= 48 && rel < 64) ? drv_val[63 - rel] : 1'b1;

  // {c22, op[1:0], phy[4:0], reg[4:0], wdata[15:0], rdval[15:0]}
  localparam logic [44:0] VEC [0:5] = '{
    {1'b1, 2'd1, 5'h01, 5'h02, 16'hBEEF, 16'h0000},
    {1'b1, 2'd2, 5'h05, 5'h1F, 16'h0000, 16'hC3A5},
    {1'b0, 2'd0, 5'h03, 5'h01, 16'h8001, 16'h0000},
    {1'b0, 2'd1, 5'h03, 5'h01, 16'h0F0F, 16'h0000},
    {1'b0, 2'd2, 5'h1F, 5'h07, 16'h0000, 16'h5A3C},
    {1'b1, 2'd1, 5'h1F, 5'h1F, 16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] r;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      hread(5'h18, r);
      if (!r[15]) return;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic c22, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [1:0] st, wop;
    logic rdop;
    rdop = (op == 2'd2);
    st   = c22 ? 2'b01 : 2'b00;
    if (c22) wop = rdop ? 2'b10 : 2'b01;
    else     wop = (op == 2'd0) ? 2'b00 : (op == 2'd1) ? 2'b01 : 2'b11;
    return {32'hFFFF_FFFF, st, wop, phy, rg, (rdop ? 2'b00 : 2'b10), (rdop ? 16'h0 : d)};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [63:0] ef, mask;
    time t1, t2;
    repeat (3) @(negedge clk);
    hread(5'h18, r); check(r == 16'h0, "R1 cmd reset", r, 0);
    hread(5'h19, r); check(r == 16'h0, "R1 data reset", r, 0);
    check(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mdio_oe, "R11 idle release", mdio_oe, 0);

    for (int i = 0; i < 6; i++) begin
      logic [44:0] v;
      logic rdop;
      v = VEC[i];
      rdop = (v[43:42] == 2'd2);
      hwrite(5'h19, v[31:16]);
      drv_val = v[15:0];
      base = rise_cnt;
      hwrite(5'h18, {1'b1, 2'b00, v[44], v[43:42], v[41:37], v[36:32]});
      hread(5'h18, r); check(r[15] == 1'b1, "R7 busy set", r, 16'h8000);
      check(r[14:0] == {2'b00, v[44], v[43:42], v[41:37], v[36:32]}, "R2 cmd fields", r, 0);
      wait_idle();
      check(rise_cnt - base == 64, "R7 frame length", rise_cnt - base, 64);
      ef   = exp_frame(v[44], v[43:42], v[41:37], v[36:32], v[31:16]);
      mask = rdop ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
      check(cap_oe == mask, rdop ? "R5 read release" : "R11 write drive", cap_oe, mask);
      check((cap & mask) == (ef & mask), v[44] ? "R3 c22 frame" : "R4 c45 frame", cap & mask, ef & mask);
      hread(5'h19, r);
      if (rdop) check(r == v[15:0], "R5 read capture", r, v[15:0]);
      else      check(r == v[31:16], "R2 data kept", r, v[31:16]);
    end

    hwrite(5'h19, 16'hA5A5);
    base = rise_cnt;
    hwrite(5'h18, 16'h9000 | (16'd1 << 10) | (16'd3 << 5) | 16'd4);
    @(posedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check(t2 - t1 == 32, "R6 mdc period", t2 - t1, 32);
    hwrite(5'h18, 16'h9000 | (16'd2 << 10) | (16'd7 << 5) | 16'd9);
    hread(5'h18, r);
    check(r == (16'h9000 | (16'd1 << 10) | (16'd3 << 5) | 16'd4), "R8 cmd ignored", r, 16'h9464);
    hwrite(5'h19, 16'h1234);
    wait_idle();
    ef = exp_frame(1'b1, 2'd1, 5'd3, 5'd4, 16'hA5A5);
    check(cap == ef, "R9 frame unchanged", cap, ef);
    check(rise_cnt - base == 64, "R8 single frame", rise_cnt - base, 64);
    hread(5'h19, r); check(r == 16'h1234, "R9 data updated", r, 16'h1234);

    base = rise_cnt;
    hwrite(5'h18, 16'h9000 | (16'd0 << 10) | 16'd5);
    hread(5'h18, r); check(r == 16'h1005, "R10 invalid refused", r, 16'h1005);
    hwrite(5'h18, 16'h0000 | (16'd1 << 10) | 16'd6);
    hread(5'h18, r); check(r == 16'h0406, "R10 no busy bit", r, 16'h0406);
    hwrite(5'h18, 16'h8000 | (16'd3 << 10));
    repeat (20) @(negedge clk);
    check(rise_cnt == base, "R10 no mdc", rise_cnt - base, 0);
    hread(5'h18, r); check(r[15] == 1'b0, "R10 busy clear", r, 16'h0C00);
    hread(5'h03, r); check(r == 16'h0, "R2 unmapped", r, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule